// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block watches the stream of completed memory requests and keeps the reservation that makes load-linked and store-conditional pairs atomic. A completed load-linked records the line and requester. A completed store-conditional reports success only when that reservation is still intact, and it always consumes the reservation. Ordinary writes by the owner, and invalidations or evictions of the reserved line, drop it. For a testing mode in which no atomicity is wanted, a bypass input makes every completion report success and leaves the reservation untouched.

The block also tracks lines held by locked read-modify-write sequences. The locked read completion raises a block event for the line, and the matching locked write completion raises an unblock event. A small table of blocked lines lets a few such sequences be open at once.

A third, independent path translates each request kind into the request class the coherence protocol sees. Both halves of a load-linked / store-conditional pair go out as atomic requests. Locked accesses go out as exclusive (store) requests.

Top module: `llsc_monitor`

## Requirements
- R1: A completed load-linked (kind code 3) sets the reservation to its line and requester id, and its response reports success (`rsp_ok_o`=1).
- R2: A completed store-conditional (kind code 4) reports `rsp_ok_o`=1 only when the reservation is held for the same line and the same requester, and reports 0 otherwise.
- R3: Every store-conditional to the reserved line clears the reservation, whether it succeeds or fails. A store-conditional to another line leaves the reservation as it was.
- R4: A completed ordinary write clears the reservation only if `cpl_present_i`=1, the line matches and the requester matches. Ordinary writes are kinds 2 (store), 5 (locked read), 6 (locked write) and 7 (flush). Otherwise the reservation is unchanged, and the response reports 1.
- R5: A locked read completion (kind 5) for a line not already blocked raises `blk_evt_o` with that line on `evt_line_o` and takes the lowest free entry of a table of NBLK lines. When the line is already blocked or the table is full, no event is raised. A locked write completion (kind 6) for a blocked line raises `unblk_evt_o` and frees its entry; for an unblocked line it raises nothing. Blocking works the same with bypass set or clear.
- R6: An issued request kind is mapped, one cycle later on `iss_cls_o`, to the following classes: 0 read for load (kind 0), 1 fetch for instruction fetch (kind 1), 2 exclusive for store, locked read and locked write (kinds 2, 5, 6), 3 atomic for load-linked and store-conditional (kinds 3, 4), and 4 flush for flush (kind 7).
- R7: With `bypass_i`=1, every completion reports `rsp_ok_o`=1 and no completion changes the reservation.
- R8: An invalidation whose line equals the reserved line clears the reservation. It takes effect before a completion in the same cycle, so a store-conditional in that cycle fails and a load-linked in that cycle still sets the reservation.
- R9: Load (kind 0) and instruction fetch (kind 1) completions leave the reservation unchanged and report 1.
- R10: Synchronous reset clears the reservation, empties the blocked-line table and drives `rsp_valid_o`, `blk_evt_o`, `unblk_evt_o` and `iss_valid_o` low.
- R11: `rsp_valid_o` is high exactly in the cycle after a cycle with `cpl_valid_i` high. Block and unblock events appear in that same cycle and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_i | input | 1 | Disable reservation handling; all completions succeed |
| cpl_valid_i | input | 1 | A request completes this cycle |
| cpl_kind_i | input | 3 | Kind of the completing request |
| cpl_line_i | input | LINE_W | Line address of the completing request |
| cpl_req_i | input | ID_W | Requester id of the completing request |
| cpl_present_i | input | 1 | The completing line is present in the cache |
| inv_valid_i | input | 1 | A line is invalidated or evicted this cycle |
| inv_line_i | input | LINE_W | Line being invalidated or evicted |
| iss_valid_i | input | 1 | A request is being issued |
| iss_kind_i | input | 3 | Kind of the issued request |
| rsp_valid_o | output | 1 | Completion result valid |
| rsp_ok_o | output | 1 | Completion success flag |
| resv_held_o | output | 1 | Reservation currently held |
| resv_line_o | output | LINE_W | Reserved line |
| resv_req_o | output | ID_W | Requester owning the reservation |
| blk_evt_o | output | 1 | One-cycle pulse: block the line on evt_line_o |
| unblk_evt_o | output | 1 | One-cycle pulse: unblock the line on evt_line_o |
| evt_line_o | output | LINE_W | Line of the latest block or unblock event |
| iss_valid_o | output | 1 | Mapped request class valid |
| iss_cls_o | output | 3 | Request class sent to the coherence protocol |

## Verification
The hardest case to reach is a completion that lands in the same cycle as an invalidation of the reserved line, in particular a store-conditional that must fail only because of that collision. Before each trial, the stimulus first establishes a known reservation with a load-linked, and for half of the trials consumes it again. It then crosses every completion kind with matching or other line, matching or other requester, present flag, bypass and three invalidation choices. This places every kind against both a held and an empty reservation. A separate sequence fills the blocked-line table, repeats a blocked line, overflows the table and frees an entry, to reach the duplicate and full cases of the table.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    K_LOAD  = 3'd0,
    K_FETCH = 3'd1,
    K_STORE = 3'd2,
    K_LINK  = 3'd3,
    K_COND  = 3'd4,
    K_LKRD  = 3'd5,
    K_LKWR  = 3'd6,
    K_FLUSH = 3'd7
  } op_kind_e;

  typedef enum logic [2:0] {
    C_READ   = 3'd0,
    C_FETCH  = 3'd1,
    C_EXCL   = 3'd2,
    C_ATOMIC = 3'd3,
    C_FLUSH  = 3'd4
  } bus_cls_e;

  function automatic bus_cls_e cls_of(op_kind_e k);
    bus_cls_e c;
    case (k)
      K_LOAD:  c = C_READ;
      K_FETCH: c = C_FETCH;
      K_LINK,
      K_COND:  c = C_ATOMIC;
      K_FLUSH: c = C_FLUSH;
      default: c = C_EXCL;
    endcase
    return c;
  endfunction

  function automatic logic is_plain_write(op_kind_e k);
    return (k == K_STORE) || (k == K_LKRD) || (k == K_LKWR) || (k == K_FLUSH);
  endfunction

endpackage

// File: rtl/llsc_resv.sv
module llsc_resv
  import llsc_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_i,
  input  logic              cpl_valid_i,
  input  op_kind_e          cpl_kind_i,
  input  logic [LINE_W-1:0] cpl_line_i,
  input  logic [ID_W-1:0]   cpl_req_i,
  input  logic              cpl_present_i,
  input  logic              inv_valid_i,
  input  logic [LINE_W-1:0] inv_line_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              held_o,
  output logic [LINE_W-1:0] line_o,
  output logic [ID_W-1:0]   req_o
);

  logic              held_q, held_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [ID_W-1:0]   req_q, req_d;
  logic              ok_d;
  logic              inv_hit, live, line_eq, req_eq;

  always_comb begin
    inv_hit = inv_valid_i && held_q && (inv_line_i == line_q);
    live    = held_q && !inv_hit;
    line_eq = (line_q == cpl_line_i);
    req_eq  = (req_q == cpl_req_i);
    held_d  = live;
    line_d  = line_q;
    req_d   = req_q;
    ok_d    = 1'b1;
    if (cpl_valid_i && !bypass_i) begin
      case (cpl_kind_i)
        K_LINK: begin
          held_d = 1'b1;
          line_d = cpl_line_i;
          req_d  = cpl_req_i;
        end
        K_COND: begin
          ok_d = live && line_eq && req_eq;
          if (live && line_eq) held_d = 1'b0;
        end
        default: begin
          if (is_plain_write(cpl_kind_i) && cpl_present_i && live && line_eq && req_eq)
            held_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= 1'b0;
      line_q      <= '0;
      req_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
    end else begin
      held_q      <= held_d;
      line_q      <= line_d;
      req_q       <= req_d;
      rsp_valid_o <= cpl_valid_i;
      rsp_ok_o    <= cpl_valid_i && ok_d;
    end
  end

  assign held_o = held_q;
  assign line_o = line_q;
  assign req_o  = req_q;

  AST_LINK_SETS: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid_i && !bypass_i && cpl_kind_i == K_LINK)
      |=> (held_q && line_q == $past(cpl_line_i) && rsp_ok_o)); // R1

  AST_COND_FAILS: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid_i && !bypass_i && cpl_kind_i == K_COND &&
     !(held_q && line_q == cpl_line_i && req_q == cpl_req_i))
      |=> !rsp_ok_o); // R2

  AST_COND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid_i && !bypass_i && cpl_kind_i == K_COND && line_q == cpl_line_i)
      |=> !held_q); // R3

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid_i && bypass_i) |=> rsp_ok_o); // R7

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (inv_valid_i && held_q && inv_line_i == line_q &&
     !(cpl_valid_i && !bypass_i && cpl_kind_i == K_LINK))
      |=> !held_q); // R8

  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid_i && !inv_valid_i && (cpl_kind_i == K_LOAD || cpl_kind_i == K_FETCH))
      |=> ($stable(held_q) && $stable(line_q) && $stable(req_q) && rsp_ok_o)); // R9

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    cpl_valid_i |=> rsp_valid_o); // R11

endmodule

// File: rtl/llsc_lock_tbl.sv
module llsc_lock_tbl
  import llsc_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int NBLK   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpl_valid_i,
  input  op_kind_e          cpl_kind_i,
  input  logic [LINE_W-1:0] cpl_line_i,
  output logic              blk_evt_o,
  output logic              unblk_evt_o,
  output logic [LINE_W-1:0] evt_line_o
);

  logic [NBLK-1:0]   ent_v_q;
  logic [LINE_W-1:0] ent_l_q [NBLK];
  logic [NBLK-1:0]   hit;
  logic [NBLK-1:0]   grant;
  logic              taken;
  logic              alloc, release_now;

  for (genvar i = 0; i < NBLK; i++) begin : g_hit
    assign hit[i] = ent_v_q[i] && (ent_l_q[i] == cpl_line_i);
  end

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      if (!ent_v_q[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign alloc       = cpl_valid_i && (cpl_kind_i == K_LKRD) && !(|hit) && taken;
  assign release_now = cpl_valid_i && (cpl_kind_i == K_LKWR) && (|hit);

  for (genvar i = 0; i < NBLK; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_v_q[i] <= 1'b0;
        ent_l_q[i] <= '0;
      end else if (alloc && grant[i]) begin
        ent_v_q[i] <= 1'b1;
        ent_l_q[i] <= cpl_line_i;
      end else if (release_now && hit[i]) begin
        ent_v_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_evt_o   <= 1'b0;
      unblk_evt_o <= 1'b0;
      evt_line_o  <= '0;
    end else begin
      blk_evt_o   <= alloc;
      unblk_evt_o <= release_now;
      if (alloc || release_now) evt_line_o <= cpl_line_i;
    end
  end

  AST_NO_DUP_BLOCK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R5

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(blk_evt_o && unblk_evt_o)); // R5

  AST_UNBLK_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid_i && cpl_kind_i == K_LKWR && hit == '0) |=> !unblk_evt_o); // R5

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!cpl_valid_i) |=> (!blk_evt_o && !unblk_evt_o)); // R11

endmodule

// File: rtl/llsc_issue_map.sv
module llsc_issue_map
  import llsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     iss_valid_i,
  input  op_kind_e iss_kind_i,
  output logic     iss_valid_o,
  output bus_cls_e iss_cls_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid_o <= 1'b0;
      iss_cls_o   <= C_READ;
    end else begin
      iss_valid_o <= iss_valid_i;
      if (iss_valid_i) iss_cls_o <= cls_of(iss_kind_i);
    end
  end

  AST_PAIR_ATOMIC: assert property (@(posedge clk) disable iff (rst)
    (iss_valid_i && (iss_kind_i == K_LINK || iss_kind_i == K_COND))
      |=> (iss_valid_o && iss_cls_o == C_ATOMIC)); // R6

  AST_LOCKED_EXCL: assert property (@(posedge clk) disable iff (rst)
    (iss_valid_i && (iss_kind_i == K_LKRD || iss_kind_i == K_LKWR))
      |=> (iss_valid_o && iss_cls_o == C_EXCL)); // R6

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 2,
  parameter int NBLK   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_i,
  input  logic              cpl_valid_i,
  input  logic [2:0]        cpl_kind_i,
  input  logic [LINE_W-1:0] cpl_line_i,
  input  logic [ID_W-1:0]   cpl_req_i,
  input  logic              cpl_present_i,
  input  logic              inv_valid_i,
  input  logic [LINE_W-1:0] inv_line_i,
  input  logic              iss_valid_i,
  input  logic [2:0]        iss_kind_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              resv_held_o,
  output logic [LINE_W-1:0] resv_line_o,
  output logic [ID_W-1:0]   resv_req_o,
  output logic              blk_evt_o,
  output logic              unblk_evt_o,
  output logic [LINE_W-1:0] evt_line_o,
  output logic              iss_valid_o,
  output logic [2:0]        iss_cls_o
);

  op_kind_e cpl_kind, iss_kind;
  bus_cls_e iss_cls;

  assign cpl_kind  = op_kind_e'(cpl_kind_i);
  assign iss_kind  = op_kind_e'(iss_kind_i);
  assign iss_cls_o = iss_cls;

  llsc_resv #(.LINE_W(LINE_W), .ID_W(ID_W)) u_resv (
    .clk           (clk),
    .rst           (rst),
    .bypass_i      (bypass_i),
    .cpl_valid_i   (cpl_valid_i),
    .cpl_kind_i    (cpl_kind),
    .cpl_line_i    (cpl_line_i),
    .cpl_req_i     (cpl_req_i),
    .cpl_present_i (cpl_present_i),
    .inv_valid_i   (inv_valid_i),
    .inv_line_i    (inv_line_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_ok_o      (rsp_ok_o),
    .held_o        (resv_held_o),
    .line_o        (resv_line_o),
    .req_o         (resv_req_o)
  );

  llsc_lock_tbl #(.LINE_W(LINE_W), .NBLK(NBLK)) u_lock (
    .clk         (clk),
    .rst         (rst),
    .cpl_valid_i (cpl_valid_i),
    .cpl_kind_i  (cpl_kind),
    .cpl_line_i  (cpl_line_i),
    .blk_evt_o   (blk_evt_o),
    .unblk_evt_o (unblk_evt_o),
    .evt_line_o  (evt_line_o)
  );

  llsc_issue_map u_map (
    .clk         (clk),
    .rst         (rst),
    .iss_valid_i (iss_valid_i),
    .iss_kind_i  (iss_kind),
    .iss_valid_o (iss_valid_o),
    .iss_cls_o   (iss_cls)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rsp_valid_o && !resv_held_o && !blk_evt_o && !unblk_evt_o && !iss_valid_o)); // R10

endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int LW = 8;
  localparam int IW = 2;
  localparam int NB = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          bypass_i = 1'b0;
  logic          cpl_valid_i = 1'b0;
  logic [2:0]    cpl_kind_i = '0;
  logic [LW-1:0] cpl_line_i = '0;
  logic [IW-1:0] cpl_req_i = '0;
  logic          cpl_present_i = 1'b0;
  logic          inv_valid_i = 1'b0;
  logic [LW-1:0] inv_line_i = '0;
  logic          iss_valid_i = 1'b0;
  logic [2:0]    iss_kind_i = '0;
  logic          rsp_valid_o, rsp_ok_o, resv_held_o;
  logic [LW-1:0] resv_line_o, evt_line_o;
  logic [IW-1:0] resv_req_o;
  logic          blk_evt_o, unblk_evt_o, iss_valid_o;
  logic [2:0]    iss_cls_o;

  llsc_monitor #(.LINE_W(LW), .ID_W(IW), .NBLK(NB)) dut (
    .clk(clk), .rst(rst), .bypass_i(bypass_i), .cpl_valid_i(cpl_valid_i),
    .cpl_kind_i(cpl_kind_i), .cpl_line_i(cpl_line_i), .cpl_req_i(cpl_req_i),
    .cpl_present_i(cpl_present_i), .inv_valid_i(inv_valid_i), .inv_line_i(inv_line_i),
    .iss_valid_i(iss_valid_i), .iss_kind_i(iss_kind_i), .rsp_valid_o(rsp_valid_o),
    .rsp_ok_o(rsp_ok_o), .resv_held_o(resv_held_o), .resv_line_o(resv_line_o),
    .resv_req_o(resv_req_o), .blk_evt_o(blk_evt_o), .unblk_evt_o(unblk_evt_o),
    .evt_line_o(evt_line_o), .iss_valid_o(iss_valid_o), .iss_cls_o(iss_cls_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_v;
  int m_line, m_req;
  bit mb_v [NB];
  int mb_l [NB];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_v = 0; m_line = 0; m_req = 0;
    for (int i = 0; i < NB; i++) begin mb_v[i] = 0; mb_l[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cpl_valid_i = 0; inv_valid_i = 0; iss_valid_i = 0; bypass_i = 0;
    @(posedge clk); #5;
    chk("R10", "rsp_valid", rsp_valid_o, 0);
    chk("R10", "resv_held", resv_held_o, 0);
    chk("R10", "blk_evt", blk_evt_o, 0);
    chk("R10", "unblk_evt", unblk_evt_o, 0);
    chk("R10", "iss_valid", iss_valid_o, 0);
    @(negedge clk);
    rst = 0;
    model_clear();
  endtask

  task automatic step(int kind, int line, int req, bit pres, bit byp, bit iv, int il, string tag);
    bit nv, e_ok, e_blk, e_unblk;
    int nl, nr, hit_i, free_i;
    @(negedge clk);
    cpl_valid_i = 1; cpl_kind_i = 3'(kind); cpl_line_i = LW'(line); cpl_req_i = IW'(req);
    cpl_present_i = pres; bypass_i = byp; inv_valid_i = iv; inv_line_i = LW'(il);
    nv = m_v; nl = m_line; nr = m_req; e_ok = 1;
    if (iv && m_v && il == m_line) nv = 0;
    if (!byp) begin
      if (kind == 3) begin nv = 1; nl = line; nr = req; end
      else if (kind == 4) begin
        e_ok = nv && m_line == line && m_req == req;
        if (nv && m_line == line) nv = 0;
      end else if (kind == 2 || kind >= 5) begin
        if (pres && nv && m_line == line && m_req == req) nv = 0;
      end
    end
    hit_i = -1; free_i = -1;
    for (int i = NB - 1; i >= 0; i--) begin
      if (mb_v[i] && mb_l[i] == line) hit_i = i;
      if (!mb_v[i]) free_i = i;
    end
    e_blk = (kind == 5) && hit_i < 0 && free_i >= 0;
    e_unblk = (kind == 6) && hit_i >= 0;
    @(posedge clk); #5;
    chk("R11", "rsp_valid", rsp_valid_o, 1);
    chk(tag, "rsp_ok", rsp_ok_o, e_ok);
    chk(tag, "resv_held", resv_held_o, nv);
    if (nv) begin
      chk(tag, "resv_line", int'(resv_line_o), nl);
      chk(tag, "resv_req", int'(resv_req_o), nr);
    end
    chk("R5", "blk_evt", blk_evt_o, e_blk);
    chk("R5", "unblk_evt", unblk_evt_o, e_unblk);
    if (e_blk || e_unblk) chk("R5", "evt_line", int'(evt_line_o), line);
    m_v = nv; m_line = nl; m_req = nr;
    if (e_blk) begin mb_v[free_i] = 1; mb_l[free_i] = line; end
    if (e_unblk) mb_v[hit_i] = 0;
    @(negedge clk);
    cpl_valid_i = 0; inv_valid_i = 0; bypass_i = 0;
    @(posedge clk); #5;
    chk("R11", "rsp_valid idle", rsp_valid_o, 0);
    chk("R11", "blk idle", blk_evt_o | unblk_evt_o, 0);
  endtask

  function automatic int exp_cls(int k);
    case (k)
      0: return 0;
      1: return 1;
      3, 4: return 3;
      7: return 4;
      default: return 2;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    model_clear();
    do_reset();

    // Cross every completion kind with a held or empty reservation
    for (int prior = 0; prior < 2; prior++)
      for (int k = 0; k < 8; k++)
        for (int ci = 0; ci < 2; ci++)
          for (int ri = 0; ri < 2; ri++)
            for (int pr = 0; pr < 2; pr++)
              for (int by = 0; by < 2; by++)
                for (int iv = 0; iv < 3; iv++) begin
                  step(3, 5, 1, 1, 0, 0, 0, "R1");
                  if (prior == 0) step(4, 5, 1, 1, 0, 0, 0, "R3");
                  if (by != 0) tag = "R7";
                  else if (iv == 1) tag = "R8";
                  else if (k == 3) tag = "R1";
                  else if (k == 4) tag = "R2/R3";
                  else if (k < 2) tag = "R9";
                  else tag = "R4";
                  step(k, (ci == 0) ? 5 : 9, (ri == 0) ? 1 : 2, pr[0], by[0],
                       iv != 0, (iv == 1) ? 5 : 9, tag);
                end

    // Blocked-line table: duplicate, full, unmatched release, reuse
    do_reset();
    step(5, 5, 0, 1, 0, 0, 0, "R5");
    step(5, 5, 0, 1, 0, 0, 0, "R5");
    step(5, 9, 0, 1, 1, 0, 0, "R5");
    step(5, 11, 0, 1, 0, 0, 0, "R5");
    step(6, 7, 0, 1, 0, 0, 0, "R5");
    step(6, 5, 0, 1, 0, 0, 0, "R5");
    step(5, 11, 0, 1, 0, 0, 0, "R5");
    do_reset();
    step(5, 9, 0, 1, 0, 0, 0, "R10");

    // Issue class mapping
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      iss_valid_i = 1; iss_kind_i = 3'(k);
      @(posedge clk); #5;
      chk("R6", "iss_valid", iss_valid_o, 1);
      chk("R6", "iss_cls", int'(iss_cls_o), exp_cls(k));
      @(negedge clk);
      iss_valid_i = 0;
      @(posedge clk); #5;
      chk("R6", "iss_valid idle", iss_valid_o, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule